// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block connects an internal master that always works as a 16-bit device to an external memory port. The external port may be 16 or 8 bits wide, and the width is decided again for every access. An access runs in 8-bit (narrow) mode when the configuration bit of its selected chip select is set, or when the external width pin is high. Otherwise it runs in 16-bit (wide) mode. Wide accesses pass straight through in one external cycle. Narrow accesses always move their byte on the external upper lane, and the block places that byte in the correct half of the internal word.

A word access at an even address in narrow mode is split into two external byte cycles. The first cycle uses the original address. The second cycle uses the same address with its lowest bit forced to one, so no carry into the upper bits is ever needed. Every external cycle holds the address strobe and the chosen chip select until the external data acknowledge arrives. The master receives one acknowledge after the last cycle. A word access at an odd address starts no external cycle and is answered with a bus error.

Top module: `dbw_adapter`

## Requirements
- R1: An access is narrow when the `cfg_narrow` bit at the index of its one-hot `m_cs` is 1, or when `width8_pin` is 1 at acceptance. Otherwise it is wide.
- R2: A wide access (`m_size` 0 = byte, 1 = word) makes exactly one external cycle. Its data lanes are unchanged in both directions. Lane enables are: word → `ext_ub`=1 and `ext_lb`=1; even byte → `ext_ub` only; odd byte → `ext_lb` only.
- R3: A narrow even-address byte access makes one external cycle with `ext_ub`=1 and `ext_lb`=0. A write drives `m_wdata[15:8]` on `ext_wdata[15:8]`. A read returns `ext_rdata[15:8]` on `m_rdata[15:8]` with `m_rdata[7:0]`=0.
- R4: A narrow odd-address byte access makes one external cycle. A write drives `m_wdata[7:0]` on `ext_wdata[15:8]`. A read returns `ext_rdata[15:8]` on `m_rdata[7:0]` with `m_rdata[15:8]`=0.
- R5: A narrow even-address word access makes exactly two external cycles. The second cycle uses the first address with bit 0 set to 1 and all higher bits unchanged, including an address of all ones above bit 0.
- R6: In a split word, the first cycle reads into `m_rdata[15:8]` or writes `m_wdata[15:8]`. The second cycle reads into `m_rdata[7:0]` or writes `m_wdata[7:0]`, always on external lane 15..8.
- R7: `ext_as` is high exactly during the external cycles. `ext_cs` equals the latched `m_cs` while `ext_as` is high and is 0 otherwise. The two cycles of a split word are separated by at least one cycle with `ext_as` low.
- R8: An external cycle holds `ext_as`, `ext_addr` and `ext_cs` steady until `ext_dack` is sampled high. A cycle with N wait cycles therefore lasts N+1 clocks.
- R9: `m_ack` pulses for one clock, one clock after the `ext_dack` of the last external cycle. `m_rdata` is valid while `m_ack` is high. The master lowers `m_req` in the clock after `m_ack`.
- R10: A word access with `m_addr[0]`=1 starts no external cycle. It is answered with a one-clock `m_berr` and no `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | NCS | Per-chip-select 8-bit port enable |
| width8_pin | input | 1 | External width pin; 1 forces narrow mode |
| m_req | input | 1 | Master request, held until m_ack or m_berr |
| m_cs | input | NCS | One-hot chip select from the address decoder |
| m_addr | input | AW | Master byte address |
| m_size | input | 1 | 0 = byte, 1 = word |
| m_we | input | 1 | 1 = write |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Read data returned to the master |
| m_ack | output | 1 | One-clock transfer completion |
| m_berr | output | 1 | One-clock bus error for a misaligned word |
| ext_addr | output | AW | External address |
| ext_as | output | 1 | External address strobe |
| ext_cs | output | NCS | External chip selects |
| ext_we | output | 1 | External write strobe |
| ext_ub | output | 1 | Upper lane (15..8) enable |
| ext_lb | output | 1 | Lower lane (7..0) enable |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_dack | input | 1 | External data acknowledge |

## Verification
A wrong phase bit or sequencer state shows at the external port within one clock. The count of strobe pulses is wrong, the second address has bit 0 clear or a changed upper part, or the strobe falls before `ext_dack`. A wrong lane choice shows at the master one clock after the last `ext_dack`, as a byte in the wrong half of `m_rdata` or a stale half left from an earlier access. A wrong width decision changes the number of external cycles within the same access.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2,
        ST_RESP = 2'd3
    } seq_state_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic ub;
        logic lb;
    } lane_en_t;

    // Byte of a 16-bit word addressed by A0 (big-endian: even = upper half).
    function automatic logic [BYTE_W-1:0] pick_byte(logic [DATA_W-1:0] w, logic a0);
        return a0 ? w[BYTE_W-1:0] : w[DATA_W-1:BYTE_W];
    endfunction

    // Replace the half selected by A0 with a new byte.
    function automatic logic [DATA_W-1:0] place_byte(logic [DATA_W-1:0] cur,
                                                     logic [BYTE_W-1:0] b, logic a0);
        return a0 ? {cur[DATA_W-1:BYTE_W], b} : {b, cur[BYTE_W-1:0]};
    endfunction

    function automatic lane_en_t wide_lanes(acc_size_e sz, logic a0);
        lane_en_t l;
        if (sz == SZ_WORD) begin
            l = '{ub: 1'b1, lb: 1'b1};
        end else begin
            l = '{ub: !a0, lb: a0};
        end
        return l;
    endfunction

endpackage

// File: rtl/dbw_mode_sel.sv
module dbw_mode_sel #(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0] cs,
    input  logic [NCS-1:0] cfg_narrow,
    input  logic           width8_pin,
    output logic           narrow
);
    logic [NCS-1:0] hit;

    for (genvar i = 0; i < NCS; i++) begin : g_hit
        assign hit[i] = cs[i] & cfg_narrow[i];
    end

    assign narrow = width8_pin | (|hit);
endmodule

// File: rtl/dbw_seq.sv
module dbw_seq
    import dbw_pkg::*;
#(
    parameter int AW  = 24,
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           m_req,
    input  logic [NCS-1:0] m_cs,
    input  logic [AW-1:0]  m_addr,
    input  acc_size_e      m_size,
    input  logic           m_we,
    input  logic           narrow_in,
    input  logic           ext_dack,
    output logic           m_ack,
    output logic           m_berr,
    output logic [AW-1:0]  ext_addr,
    output logic           ext_as,
    output logic [NCS-1:0] ext_cs,
    output logic           ext_we,
    output logic           start,
    output logic           capture,
    output logic           narrow_q,
    output acc_size_e      size_q,
    output logic           cur_a0
);
    seq_state_e     st_q, st_d;
    logic [AW-1:0]  addr_q;
    logic [NCS-1:0] cs_q;
    logic           we_q, split_q, phase_q, err_q;
    logic           accept, misalign, last_dack;

    assign accept    = (st_q == ST_IDLE) && m_req;
    assign misalign  = (m_size == SZ_WORD) && m_addr[0];
    assign start     = accept && !misalign;
    assign capture   = (st_q == ST_XFER) && ext_dack;
    assign last_dack = capture && !(split_q && !phase_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)  st_d = misalign ? ST_RESP : ST_XFER;
            ST_XFER: if (capture) st_d = last_dack ? ST_RESP : ST_GAP;
            ST_GAP:  st_d = ST_XFER;
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            addr_q   <= '0;
            cs_q     <= '0;
            we_q     <= 1'b0;
            split_q  <= 1'b0;
            phase_q  <= 1'b0;
            err_q    <= 1'b0;
            narrow_q <= 1'b0;
            size_q   <= SZ_BYTE;
        end else begin
            st_q <= st_d;
            if (accept) begin
                addr_q   <= m_addr;
                cs_q     <= m_cs;
                we_q     <= m_we;
                size_q   <= m_size;
                narrow_q <= narrow_in;
                split_q  <= narrow_in && (m_size == SZ_WORD);
                phase_q  <= 1'b0;
                err_q    <= misalign;
            end else if (capture && !last_dack) begin
                phase_q <= 1'b1;
            end
        end
    end

    assign cur_a0   = addr_q[0] | phase_q;
    assign ext_addr = {addr_q[AW-1:1], cur_a0};
    assign ext_as   = (st_q == ST_XFER);
    assign ext_cs   = ext_as ? cs_q : '0;
    assign ext_we   = ext_as && we_q;
    assign m_ack    = (st_q == ST_RESP) && !err_q;
    assign m_berr   = (st_q == ST_RESP) && err_q;

    AST_CS_DURING_AS: assert property (@(posedge clk) disable iff (rst)
        ext_as |-> (ext_cs != '0)) else $error("cs missing with strobe"); // R7

    AST_HOLD_UNTIL_DACK: assert property (@(posedge clk) disable iff (rst)
        (ext_as && !ext_dack) |=> (ext_as && $stable(ext_addr) && $stable(ext_cs)))
        else $error("cycle dropped before dack"); // R8

    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
        (ext_as && $past(st_q) == ST_GAP) |->
        (ext_addr[0] && ext_addr[AW-1:1] == $past(ext_addr[AW-1:1], 2)))
        else $error("second half address wrong"); // R5

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        m_ack |=> !m_ack) else $error("ack longer than one clock"); // R9

    AST_ACK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (m_ack || m_berr) |-> !ext_as) else $error("response during cycle"); // R9

    AST_BERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        m_berr |-> ($past(st_q) == ST_IDLE && !m_ack))
        else $error("bus error after a cycle"); // R10
endmodule

// File: rtl/dbw_lanes.sv
module dbw_lanes
    import dbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              capture,
    input  logic              active,
    input  logic              narrow,
    input  acc_size_e         size,
    input  logic              a0,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_ub,
    output logic              ext_lb,
    output logic [DATA_W-1:0] m_rdata
);
    logic [DATA_W-1:0] wbuf_q, rbuf_q;
    lane_en_t          lanes;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else if (start) begin
            wbuf_q <= m_wdata;
            rbuf_q <= '0;
        end else if (capture) begin
            rbuf_q <= narrow ? place_byte(rbuf_q, ext_rdata[DATA_W-1:BYTE_W], a0)
                             : ext_rdata;
        end
    end

    always_comb begin
        if (narrow) begin
            ext_wdata = {pick_byte(wbuf_q, a0), {BYTE_W{1'b0}}};
            lanes     = '{ub: 1'b1, lb: 1'b0};
        end else begin
            ext_wdata = wbuf_q;
            lanes     = wide_lanes(size, a0);
        end
    end

    assign ext_ub  = active && lanes.ub;
    assign ext_lb  = active && lanes.lb;
    assign m_rdata = rbuf_q;

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (capture && narrow) |=> (rbuf_q[DATA_W-1:BYTE_W] == $past(ext_rdata[DATA_W-1:BYTE_W])
                                 || rbuf_q[BYTE_W-1:0] == $past(ext_rdata[DATA_W-1:BYTE_W])))
        else $error("narrow byte not stored"); // R6
endmodule

// File: rtl/dbw_adapter.sv
module dbw_adapter
    import dbw_pkg::*;
#(
    parameter int AW  = 24,
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCS-1:0] cfg_narrow,
    input  logic           width8_pin,
    input  logic           m_req,
    input  logic [NCS-1:0] m_cs,
    input  logic [AW-1:0]  m_addr,
    input  logic           m_size,
    input  logic           m_we,
    input  logic [15:0]    m_wdata,
    output logic [15:0]    m_rdata,
    output logic           m_ack,
    output logic           m_berr,
    output logic [AW-1:0]  ext_addr,
    output logic           ext_as,
    output logic [NCS-1:0] ext_cs,
    output logic           ext_we,
    output logic           ext_ub,
    output logic           ext_lb,
    output logic [15:0]    ext_wdata,
    input  logic [15:0]    ext_rdata,
    input  logic           ext_dack
);
    logic      narrow_sel, start, capture, narrow_q, cur_a0;
    acc_size_e size_q;

    dbw_mode_sel #(.NCS(NCS)) mode_i (
        .cs         (m_cs),
        .cfg_narrow (cfg_narrow),
        .width8_pin (width8_pin),
        .narrow     (narrow_sel)
    );

    dbw_seq #(.AW(AW), .NCS(NCS)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .m_req     (m_req),
        .m_cs      (m_cs),
        .m_addr    (m_addr),
        .m_size    (acc_size_e'(m_size)),
        .m_we      (m_we),
        .narrow_in (narrow_sel),
        .ext_dack  (ext_dack),
        .m_ack     (m_ack),
        .m_berr    (m_berr),
        .ext_addr  (ext_addr),
        .ext_as    (ext_as),
        .ext_cs    (ext_cs),
        .ext_we    (ext_we),
        .start     (start),
        .capture   (capture),
        .narrow_q  (narrow_q),
        .size_q    (size_q),
        .cur_a0    (cur_a0)
    );

    dbw_lanes lanes_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .capture   (capture),
        .active    (ext_as),
        .narrow    (narrow_q),
        .size      (size_q),
        .a0        (cur_a0),
        .m_wdata   (m_wdata),
        .ext_rdata (ext_rdata),
        .ext_wdata (ext_wdata),
        .ext_ub    (ext_ub),
        .ext_lb    (ext_lb),
        .m_rdata   (m_rdata)
    );
endmodule

// File: tb/dbw_adapter_tb_top.sv
module dbw_adapter_tb_top;
    localparam int AW  = 24;
    localparam int NCS = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCS-1:0] cfg_narrow = 4'b0101;
    logic           width8_pin = 1'b0;
    logic           m_req = 1'b0;
    logic [NCS-1:0] m_cs = '0;
    logic [AW-1:0]  m_addr = '0;
    logic           m_size = 1'b0;
    logic           m_we = 1'b0;
    logic [15:0]    m_wdata = '0;
    logic [15:0]    m_rdata;
    logic           m_ack, m_berr;
    logic [AW-1:0]  ext_addr;
    logic           ext_as, ext_we, ext_ub, ext_lb;
    logic [NCS-1:0] ext_cs;
    logic [15:0]    ext_wdata;
    logic [15:0]    ext_rdata = '0;
    logic           ext_dack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    // per-access log
    int             ncyc, nrise;
    logic [AW-1:0]  l_addr [4];
    logic [AW-1:0]  l_addr0[4];
    logic [15:0]    l_wd   [4];
    logic           l_ub   [4];
    logic           l_lb   [4];
    logic           l_we   [4];
    logic [NCS-1:0] l_cs   [4];
    int             l_hold [4];
    logic [15:0]    got_rd;
    logic           got_ack, got_berr;

    dbw_adapter #(.AW(AW), .NCS(NCS)) dut_i (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d expected <100000", cyc_cnt);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] bm(logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input logic [NCS-1:0] cs, input logic [AW-1:0] addr,
                              input logic word, input logic we, input logic [15:0] wd,
                              input logic pin, input logic mem_narrow, input int waits);
        int  hold = 0;
        int  tmo = 0;
        logic as_prev = 1'b0;
        @(negedge clk);
        m_cs = cs; m_addr = addr; m_size = word; m_we = we; m_wdata = wd;
        width8_pin = pin; m_req = 1'b1; ext_dack = 1'b0;
        ncyc = 0; nrise = 0; got_ack = 0; got_berr = 0;
        forever begin
            @(negedge clk);
            ext_dack = 1'b0;
            if (m_ack || m_berr) begin
                got_ack = m_ack; got_berr = m_berr; got_rd = m_rdata;
                m_req = 1'b0;
                break;
            end
            if (ext_as) begin
                if (!as_prev) begin
                    hold = 0; nrise++;
                    if (ncyc < 4) l_addr0[ncyc] = ext_addr;
                end
                hold++;
                ext_rdata = mem_narrow ? {bm(ext_addr), 8'hEE}
                                       : {bm({ext_addr[AW-1:1], 1'b0}), bm({ext_addr[AW-1:1], 1'b1})};
                if (hold == waits + 1 && ncyc < 4) begin
                    ext_dack = 1'b1;
                    l_addr[ncyc] = ext_addr; l_wd[ncyc] = ext_wdata; l_ub[ncyc] = ext_ub;
                    l_lb[ncyc] = ext_lb; l_we[ncyc] = ext_we; l_cs[ncyc] = ext_cs;
                    l_hold[ncyc] = hold;
                    ncyc++;
                end
            end
            as_prev = ext_as;
            tmo++;
            if (tmo > 60) begin
                chk(1'b0, "access timeout", 32'(tmo), 32'd60);
                m_req = 1'b0;
                break;
            end
        end
        @(negedge clk);
        chk(!m_ack && !m_berr && !ext_as, "R9 single response", {30'd0, m_ack, m_berr}, 0);
    endtask

    task automatic t_reset();
        chk(!ext_as && ext_cs == 0 && !m_ack && !m_berr, "R7 reset idle",
            {ext_as, ext_cs, m_ack, m_berr}, 0);
    endtask

    task automatic t_wide_word_read();
        logic [AW-1:0] a = 24'h000100;
        run_access(4'b0010, a, 1, 0, 0, 0, 0, 0);
        chk(ncyc == 1 && nrise == 1, "R1 R2 wide word one cycle", ncyc, 1);
        chk(l_ub[0] && l_lb[0] && !l_we[0], "R2 wide word lanes", {l_ub[0], l_lb[0]}, 2'b11);
        chk(got_ack && got_rd == {bm(a), bm(a | 1)}, "R2 wide word data", got_rd, {bm(a), bm(a | 1)});
        chk(l_cs[0] == 4'b0010, "R7 cs wide", l_cs[0], 4'b0010);
    endtask

    task automatic t_wide_byte_write();
        run_access(4'b0010, 24'h000203, 0, 1, 16'hC3D4, 0, 0, 1);
        chk(ncyc == 1 && l_we[0], "R2 wide byte write one cycle", ncyc, 1);
        chk(!l_ub[0] && l_lb[0], "R2 odd byte lower lane", {l_ub[0], l_lb[0]}, 2'b01);
        chk(l_wd[0] == 16'hC3D4 && l_addr[0] == 24'h000203, "R2 wide data unchanged", l_wd[0], 16'hC3D4);
        chk(l_hold[0] == 2 && nrise == 1, "R8 one wait holds strobe", l_hold[0], 2);
    endtask

    task automatic t_narrow_even_byte_read();
        logic [AW-1:0] a = 24'h000410;
        run_access(4'b0001, a, 0, 0, 0, 0, 1, 2);
        chk(ncyc == 1 && nrise == 1, "R3 even byte one cycle", ncyc, 1);
        chk(l_ub[0] && !l_lb[0], "R3 upper lane only", {l_ub[0], l_lb[0]}, 2'b10);
        chk(got_rd == {bm(a), 8'h00}, "R3 even byte to upper half", got_rd, {bm(a), 8'h00});
        chk(l_hold[0] == 3 && l_addr0[0] == l_addr[0], "R8 two waits addr stable", l_hold[0], 3);
    endtask

    task automatic t_narrow_odd_byte_read();
        logic [AW-1:0] a = 24'h000411;
        run_access(4'b0001, a, 0, 0, 0, 0, 1, 0);
        chk(ncyc == 1, "R4 odd byte read one cycle", ncyc, 1);
        chk(got_rd == {8'h00, bm(a)}, "R4 odd byte to lower half", got_rd, {8'h00, bm(a)});
    endtask

    task automatic t_narrow_odd_byte_write();
        run_access(4'b0100, 24'h000555, 0, 1, 16'h1289, 0, 1, 0);
        chk(ncyc == 1 && l_addr[0] == 24'h000555, "R4 odd byte write one cycle", ncyc, 1);
        chk(l_wd[0][15:8] == 8'h89 && l_ub[0] && !l_lb[0], "R4 lower byte on upper lane",
            l_wd[0][15:8], 8'h89);
    endtask

    task automatic t_narrow_word_read();
        logic [AW-1:0] a = 24'h001234;
        run_access(4'b0001, a, 1, 0, 0, 0, 1, 1);
        chk(ncyc == 2 && nrise == 2, "R5 R7 split word two strobes", nrise, 2);
        chk(l_addr[0] == a && l_addr[1] == (a | 1), "R5 second address", l_addr[1], a | 1);
        chk(got_ack && got_rd == {bm(a), bm(a | 1)}, "R6 split read assembly", got_rd, {bm(a), bm(a | 1)});
        chk(l_cs[0] == 4'b0001 && l_cs[1] == 4'b0001, "R7 cs each cycle", l_cs[1], 4'b0001);
    endtask

    task automatic t_narrow_word_write();
        run_access(4'b0100, 24'h0000A0, 1, 1, 16'hBEEF, 0, 1, 0);
        chk(ncyc == 2 && l_we[0] && l_we[1], "R5 split write two cycles", ncyc, 2);
        chk(l_wd[0][15:8] == 8'hBE, "R6 first half upper byte", l_wd[0][15:8], 8'hBE);
        chk(l_wd[1][15:8] == 8'hEF && l_addr[1] == 24'h0000A1, "R6 second half lower byte",
            l_wd[1][15:8], 8'hEF);
    endtask

    task automatic t_pin_narrow();
        logic [AW-1:0] a = 24'h000300;
        run_access(4'b0010, a, 1, 0, 0, 1, 1, 0);
        chk(ncyc == 2, "R1 width pin forces narrow", ncyc, 2);
        chk(got_rd == {bm(a), bm(a | 1)}, "R1 pin narrow data", got_rd, {bm(a), bm(a | 1)});
    endtask

    task automatic t_misaligned();
        run_access(4'b0001, 24'h000401, 1, 0, 0, 0, 1, 0);
        chk(got_berr && !got_ack, "R10 bus error", {got_berr, got_ack}, 2'b10);
        chk(nrise == 0, "R10 no external cycle", nrise, 0);
    endtask

    task automatic t_top_address();
        run_access(4'b0001, 24'hFFFFFE, 1, 0, 0, 0, 1, 0);
        chk(l_addr[1] == 24'hFFFFFF && l_addr[0] == 24'hFFFFFE, "R5 no carry at top",
            l_addr[1], 24'hFFFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_word_read();
        t_wide_byte_write();
        t_narrow_even_byte_read();
        t_narrow_odd_byte_read();
        t_narrow_odd_byte_write();
        t_narrow_word_read();
        t_narrow_word_write();
        t_pin_narrow();
        t_misaligned();
        t_top_address();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule